// File: doc/BRIEF.md
# Indexed Table Gather Engine

The engine fills a local destination buffer from an external table memory. A local index buffer controls which table data is read. One static parameter selects how coarse each fetch is.

In row mode, every destination row has one index entry. That index selects a whole table row, and the engine copies the valid columns of that row. The table row pitch is a runtime value, so a table row may be padded wider than the valid width. In element mode, the index array has the same valid shape as the destination. Each index picks one element of the table, seen as a flat array.

Before an index is turned into an address, it passes through a runtime out-of-range policy. The policy can pass the index unchanged, clamp it, wrap it, or substitute zero data. Capacity is counted in table rows in row mode and in flat elements in element mode.

A caller loads the configuration and pulses start. It then waits for a one-cycle done pulse. The engine reads index entries through a synchronous read port. It issues single-word table reads, keeping at most one outstanding. It writes destination slots one at a time, in row-major order.

Top module: `tbl_gather`

## Requirements
- R1: In row mode (ELEM_MODE=0), destination slot (r,c) receives the table word at address base + e(idx[r])*row_stride + c, for every c below the valid column count. The row stride may exceed the valid column count.
- R2: In element mode (ELEM_MODE=1), destination slot (r,c) receives the table word at base + e(idx[r][c]). The index at (r,c) is read from the index port with row r and column c.
- R3: Policy code 0 applies no check: e(i) = i, even when i is at or beyond capacity.
- R4: Policy code 1 clamps: an out-of-range index maps to capacity-1, and an in-range index is unchanged.
- R5: Policy code 2 wraps: e(i) is the unsigned value of i modulo capacity, whatever the signed flag says.
- R6: Policy code 3 writes zero into every destination slot whose index is out of range. No table read is issued for that slot, so a row-mode row with an out-of-range index causes no table reads at all.
- R7: Only the valid region is written, in row-major order with the column advancing first. Valid rows and valid columns are each at least 1, and a 1x1 request works.
- R8: At most one table read is outstanding, and the engine issues exactly one read per non-zero-filled destination slot.
- R9: busy_o goes high in the cycle after an accepted start. It stays high through the done pulse. done_o is high for exactly one cycle, one cycle after the last destination write.
- R10: A start while busy_o is high is ignored. The configuration is captured when start is accepted, so input changes during a run have no effect on it.
- R11: After reset, busy_o, done_o, idx_rd_o, tbl_req_o and dst_we_o are low.
- R12: An index is out of range when it is at or above capacity (both treated as unsigned). When idx_signed_i is 1, any index with bit 31 set is also out of range. Capacity must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| oob_mode_i | input | 2 | Out-of-range policy: 0 none, 1 clamp, 2 wrap, 3 zero |
| idx_signed_i | input | 1 | Treat indices as signed |
| valid_rows_i | input | CW | Valid destination rows (at least 1) |
| valid_cols_i | input | CW | Valid destination columns (at least 1) |
| capacity_i | input | IW | Table rows (row mode) or table elements (element mode) |
| tbl_base_i | input | AW | Table base word address |
| row_stride_i | input | AW | Table row pitch in words (row mode) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| idx_rd_o | output | 1 | Index read strobe, data returned next cycle |
| idx_row_o | output | CW | Index row address |
| idx_col_o | output | CW | Index column address (zero in row mode) |
| idx_data_i | input | IW | Index read data |
| tbl_req_o | output | 1 | Table read request (one cycle) |
| tbl_addr_o | output | AW | Table word address |
| tbl_rvalid_i | input | 1 | Table read response valid |
| tbl_rdata_i | input | DW | Table read data |
| dst_we_o | output | 1 | Destination write strobe |
| dst_row_o | output | CW | Destination row |
| dst_col_o | output | CW | Destination column |
| dst_data_o | output | DW | Destination write data |

## Verification
Row gathers run with a padded row pitch and with scattered in-range indices. This separates address arithmetic based on the pitch from arithmetic based on the width. The same row workload is then rerun under clamp, wrap and zero policies. Those indices lie beyond capacity, are negative when signed, or are large when unsigned, which separates the three remaps and the treatment of the signed flag.

The zero policy is judged both by the data written and by the count of table reads, so a skipped read shows up even though the data alone would look right. Element gathers cover the 1x1 shape and rectangular shapes under each policy. Table latency varies from run to run, and a second start during a run checks that the latched configuration is kept.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    OOB_NONE  = 2'd0,
    OOB_CLAMP = 2'd1,
    OOB_WRAP  = 2'd2,
    OOB_ZERO  = 2'd3
  } oob_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX,
    ST_MAP,
    ST_REQ,
    ST_WAIT,
    ST_ZERO
  } st_e;
endpackage

// File: rtl/tg_oob_remap.sv
module tg_oob_remap
  import tg_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [IW-1:0] idx_i,
  input  logic          idx_signed_i,
  input  oob_e          mode_i,
  input  logic [IW-1:0] cap_i,
  output logic [IW-1:0] eff_o,
  output logic          zero_o
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic neg, oor;

  always_comb begin
    neg    = idx_signed_i & idx_i[IW-1];
    oor    = neg | (idx_i >= cap_i);
    eff_o  = idx_i;
    zero_o = 1'b0;
    unique case (mode_i)
      OOB_CLAMP: eff_o = oor ? (cap_i - ONE) : idx_i;
      OOB_WRAP:  eff_o = idx_i % cap_i;
      OOB_ZERO:  zero_o = oor;
      default:   eff_o = idx_i;
    endcase
  end
endmodule

// File: rtl/tg_addr_gen.sv
module tg_addr_gen #(
  parameter bit          ELEM_MODE = 1'b0,
  parameter int unsigned AW        = 32,
  parameter int unsigned IW        = 32,
  parameter int unsigned CW        = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [IW-1:0] eff_i,
  input  logic [CW-1:0] col_i,
  output logic [AW-1:0] addr_o
);
  generate
    if (ELEM_MODE) begin : g_elem
      logic unused_row_fields;
      assign unused_row_fields = ^{stride_i, col_i};
      assign addr_o = base_i + AW'(eff_i);
    end else begin : g_row
      assign addr_o = base_i + (AW'(eff_i) * stride_i) + AW'(col_i);
    end
  endgenerate
endmodule

// File: rtl/tg_walk_cnt.sv
module tg_walk_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] rows_i,
  input  logic [CW-1:0] cols_i,
  output logic [CW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          last_col_o,
  output logic          last_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] row_q, col_q;

  assign last_col_o = (col_q == cols_i - ONE);
  assign last_o     = last_col_o & (row_q == rows_i - ONE);
  assign row_o      = row_q;
  assign col_o      = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step_i) begin
      if (last_col_o) begin
        col_q <= '0;
        row_q <= row_q + ONE;
      end else begin
        col_q <= col_q + ONE;
      end
    end
  end
endmodule

// File: rtl/tbl_gather.sv
module tbl_gather
  import tg_pkg::*;
#(
  parameter bit          ELEM_MODE = 1'b0,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 32,
  parameter int unsigned IW        = 32,
  parameter int unsigned CW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    oob_mode_i,
  input  logic          idx_signed_i,
  input  logic [CW-1:0] valid_rows_i,
  input  logic [CW-1:0] valid_cols_i,
  input  logic [IW-1:0] capacity_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [AW-1:0] row_stride_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          idx_rd_o,
  output logic [CW-1:0] idx_row_o,
  output logic [CW-1:0] idx_col_o,
  input  logic [IW-1:0] idx_data_i,
  output logic          tbl_req_o,
  output logic [AW-1:0] tbl_addr_o,
  input  logic          tbl_rvalid_i,
  input  logic [DW-1:0] tbl_rdata_i,
  output logic          dst_we_o,
  output logic [CW-1:0] dst_row_o,
  output logic [CW-1:0] dst_col_o,
  output logic [DW-1:0] dst_data_o
);
  localparam logic [DW-1:0] ZERO_WORD = '0;

  st_e           st_q, st_d, after_wr;
  logic          done_q, accept, wr_fire;
  oob_e          oob_q;
  logic          sgn_q, zero_q, zero_c;
  logic [CW-1:0] rows_q, cols_q, row, col;
  logic [IW-1:0] cap_q, eff_q, eff_c;
  logic [AW-1:0] base_q, stride_q;
  logic          last_col, last_all;

  assign busy_o = (st_q != ST_IDLE) | done_q;
  assign accept = start_i & ~busy_o;

  // configuration is frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oob_q    <= OOB_NONE;
      sgn_q    <= 1'b0;
      rows_q   <= '0;
      cols_q   <= '0;
      cap_q    <= '0;
      base_q   <= '0;
      stride_q <= '0;
    end else if (accept) begin
      oob_q    <= oob_e'(oob_mode_i);
      sgn_q    <= idx_signed_i;
      rows_q   <= valid_rows_i;
      cols_q   <= valid_cols_i;
      cap_q    <= capacity_i;
      base_q   <= tbl_base_i;
      stride_q <= row_stride_i;
    end
  end

  tg_oob_remap #(.IW(IW)) u_remap (
    .idx_i        (idx_data_i),
    .idx_signed_i (sgn_q),
    .mode_i       (oob_q),
    .cap_i        (cap_q),
    .eff_o        (eff_c),
    .zero_o       (zero_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= '0;
      zero_q <= 1'b0;
    end else if (st_q == ST_MAP) begin
      eff_q  <= eff_c;
      zero_q <= zero_c;
    end
  end

  tg_walk_cnt #(.CW(CW)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .step_i     (wr_fire),
    .rows_i     (rows_q),
    .cols_i     (cols_q),
    .row_o      (row),
    .col_o      (col),
    .last_col_o (last_col),
    .last_o     (last_all)
  );

  tg_addr_gen #(.ELEM_MODE(ELEM_MODE), .AW(AW), .IW(IW), .CW(CW)) u_addr (
    .base_i   (base_q),
    .stride_i (stride_q),
    .eff_i    (eff_q),
    .col_i    (col),
    .addr_o   (tbl_addr_o)
  );

  assign wr_fire = ((st_q == ST_WAIT) & tbl_rvalid_i) | (st_q == ST_ZERO);

  always_comb begin
    if (last_all)                   after_wr = ST_IDLE;
    else if (ELEM_MODE || last_col) after_wr = ST_IDX;
    else if (zero_q)                after_wr = ST_ZERO;
    else                            after_wr = ST_REQ;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_IDX;
      ST_IDX:  st_d = ST_MAP;
      ST_MAP:  st_d = zero_c ? ST_ZERO : ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (tbl_rvalid_i) st_d = after_wr;
      ST_ZERO: st_d = after_wr;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= wr_fire & last_all;
    end
  end

  generate
    if (ELEM_MODE) begin : g_idx_col
      assign idx_col_o = col;
    end else begin : g_idx_row
      assign idx_col_o = '0;
    end
  endgenerate

  assign done_o     = done_q;
  assign idx_rd_o   = (st_q == ST_IDX);
  assign idx_row_o  = row;
  assign tbl_req_o  = (st_q == ST_REQ);
  assign dst_we_o   = wr_fire;
  assign dst_row_o  = row;
  assign dst_col_o  = col;
  assign dst_data_o = (st_q == ST_ZERO) ? ZERO_WORD : tbl_rdata_i;
endmodule

// File: rtl/tbl_gather_chk.sv
module tbl_gather_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [CW-1:0] valid_cols_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          idx_rd_o,
  input logic          tbl_req_o,
  input logic          tbl_rvalid_i,
  input logic          dst_we_o,
  input logic [CW-1:0] dst_col_o
);
  logic          out_q;
  logic [CW-1:0] vc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      vc_q  <= '0;
    end else begin
      if (tbl_req_o)         out_q <= 1'b1;
      else if (tbl_rvalid_i) out_q <= 1'b0;
      if (start_i && !busy_o) vc_q <= valid_cols_i;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tbl_req_o && !dst_we_o && !idx_rd_o && !done_o)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o |-> !out_q); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(dst_we_o)); // R9
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9
  AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> (dst_col_o < vc_q)); // R7
endmodule

bind tbl_gather tbl_gather_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .valid_cols_i (valid_cols_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .idx_rd_o     (idx_rd_o),
  .tbl_req_o    (tbl_req_o),
  .tbl_rvalid_i (tbl_rvalid_i),
  .dst_we_o     (dst_we_o),
  .dst_col_o    (dst_col_o)
);

// File: tb/tbl_gather_tb_top.sv
package tg_tb_pkg;
  function automatic logic [31:0] tbl_val(logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'hC3C3_0001;
  endfunction

  // returns {zero_fill, effective_index}
  function automatic logic [32:0] ref_map(logic [31:0] idx, logic sg, logic [1:0] m,
                                          logic [31:0] cap);
    logic oor;
    oor = (sg && idx[31]) || (idx >= cap);
    case (m)
      2'd1:    return {1'b0, oor ? cap - 32'd1 : idx};
      2'd2:    return {1'b0, idx % cap};
      2'd3:    return {oor, idx};
      default: return {1'b0, idx};
    endcase
  endfunction
endpackage

module tg_tbl_model (
  input  logic        clk,
  input  logic        rst_n,
  input  int          lat,
  input  logic        req,
  input  logic [31:0] addr,
  output logic        rvalid,
  output logic [31:0] rdata
);
  logic        pend;
  int          w;
  logic [31:0] a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; rvalid <= 1'b0; rdata <= '0; w <= 0; a <= '0;
    end else begin
      rvalid <= 1'b0;
      if (pend) begin
        if (w == 0) begin
          rvalid <= 1'b1;
          rdata  <= tg_tb_pkg::tbl_val(a);
          pend   <= 1'b0;
        end else w <= w - 1;
      end else if (req) begin
        pend <= 1'b1; w <= lat; a <= addr;
      end
    end
  end
endmodule

module tbl_gather_tb_top;
  import tg_tb_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // row-mode DUT signals
  logic        start_r = 0, sg_r = 0, busy_r, done_r, idx_rd_r, req_r, rv_r, we_r;
  logic [1:0]  oob_r = 0;
  logic [7:0]  vr_r = 1, vc_r = 1, idx_row_r, idx_col_r, drow_r, dcol_r;
  logic [31:0] cap_r = 1, base_r = 0, stride_r = 0, idx_data_r = 0, addr_r, rd_r, ddat_r;
  int          lat_r = 0;
  logic [31:0] idx_mem_r [0:15];

  // element-mode DUT signals
  logic        start_e = 0, sg_e = 0, busy_e, done_e, idx_rd_e, req_e, rv_e, we_e;
  logic [1:0]  oob_e = 0;
  logic [7:0]  vr_e = 1, vc_e = 1, idx_row_e, idx_col_e, drow_e, dcol_e;
  logic [31:0] cap_e = 1, base_e = 0, idx_data_e = 0, addr_e, rd_e, ddat_e;
  int          lat_e = 0;
  logic [31:0] idx_mem_e [0:255];

  tbl_gather #(.ELEM_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_r), .oob_mode_i(oob_r),
    .idx_signed_i(sg_r), .valid_rows_i(vr_r), .valid_cols_i(vc_r), .capacity_i(cap_r),
    .tbl_base_i(base_r), .row_stride_i(stride_r), .busy_o(busy_r), .done_o(done_r),
    .idx_rd_o(idx_rd_r), .idx_row_o(idx_row_r), .idx_col_o(idx_col_r),
    .idx_data_i(idx_data_r), .tbl_req_o(req_r), .tbl_addr_o(addr_r),
    .tbl_rvalid_i(rv_r), .tbl_rdata_i(rd_r), .dst_we_o(we_r), .dst_row_o(drow_r),
    .dst_col_o(dcol_r), .dst_data_o(ddat_r));

  tbl_gather #(.ELEM_MODE(1'b1)) dut_elem_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_e), .oob_mode_i(oob_e),
    .idx_signed_i(sg_e), .valid_rows_i(vr_e), .valid_cols_i(vc_e), .capacity_i(cap_e),
    .tbl_base_i(base_e), .row_stride_i(32'd0), .busy_o(busy_e), .done_o(done_e),
    .idx_rd_o(idx_rd_e), .idx_row_o(idx_row_e), .idx_col_o(idx_col_e),
    .idx_data_i(idx_data_e), .tbl_req_o(req_e), .tbl_addr_o(addr_e),
    .tbl_rvalid_i(rv_e), .tbl_rdata_i(rd_e), .dst_we_o(we_e), .dst_row_o(drow_e),
    .dst_col_o(dcol_e), .dst_data_o(ddat_e));

  tg_tbl_model u_tbl_r (.clk(clk), .rst_n(rst_n), .lat(lat_r), .req(req_r), .addr(addr_r),
                        .rvalid(rv_r), .rdata(rd_r));
  tg_tbl_model u_tbl_e (.clk(clk), .rst_n(rst_n), .lat(lat_e), .req(req_e), .addr(addr_e),
                        .rvalid(rv_e), .rdata(rd_e));

  always @(posedge clk) begin
    if (idx_rd_r) idx_data_r <= idx_mem_r[idx_row_r[3:0]];
    if (idx_rd_e) idx_data_e <= idx_mem_e[{idx_row_e[3:0], idx_col_e[3:0]}];
  end

  task automatic chk(input string what, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // expected write streams {row, col, data} in walk order
  logic [47:0] q_r[$], q_e[$];
  string tag_r = "", tag_e = "";
  int nreq_r = 0, nreq_e = 0, ndone_r = 0, ndone_e = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_r) nreq_r++;
      if (req_e) nreq_e++;
      if (done_r) ndone_r++;
      if (done_e) ndone_e++;
      if (we_r) begin
        if (q_r.size() == 0) chk({tag_r, " extra write"}, {drow_r, dcol_r, ddat_r}, 48'h0);
        else chk({tag_r, " write"}, {drow_r, dcol_r, ddat_r}, q_r.pop_front());
      end
      if (we_e) begin
        if (q_e.size() == 0) chk({tag_e, " extra write"}, {drow_e, dcol_e, ddat_e}, 48'h0);
        else chk({tag_e, " write"}, {drow_e, dcol_e, ddat_e}, q_e.pop_front());
      end
    end
  end

  task automatic run_row(input string tag, input int vr, input int vc, input logic [1:0] m,
                         input logic sg, input logic [31:0] cap, input logic [31:0] base,
                         input logic [31:0] stride, input int lat, input bit restart);
    logic [32:0] mp;
    int exp_req = 0;
    q_r.delete(); tag_r = tag; nreq_r = 0; ndone_r = 0;
    for (int r = 0; r < vr; r++) begin
      mp = ref_map(idx_mem_r[r], sg, m, cap);
      for (int c = 0; c < vc; c++) begin
        if (mp[32]) q_r.push_back({8'(r), 8'(c), 32'h0});
        else begin
          q_r.push_back({8'(r), 8'(c), tbl_val(base + mp[31:0] * stride + 32'(c))});
          exp_req++;
        end
      end
    end
    @(negedge clk);
    vr_r = 8'(vr); vc_r = 8'(vc); oob_r = m; sg_r = sg; cap_r = cap; base_r = base;
    stride_r = stride; lat_r = lat; start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0;
    chk({tag, " R9 busy after start"}, {47'h0, busy_r}, 48'h1);
    if (restart) begin
      repeat (5) @(negedge clk);
      vc_r = 8'd1; base_r = 32'd0; oob_r = 2'd3; start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
    end
    for (int k = 0; k < 5000; k++) begin
      if (done_r) break;
      @(negedge clk);
    end
    chk({tag, " R9 done seen"}, {47'h0, done_r}, 48'h1);
    chk({tag, " R9 busy during done"}, {47'h0, busy_r}, 48'h1);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, {47'h0, done_r}, 48'h0);
    chk({tag, " R9 idle after done"}, {47'h0, busy_r}, 48'h0);
    chk({tag, " R7 all writes made"}, 48'(q_r.size()), 48'h0);
    chk({tag, " R8 table read count"}, 48'(nreq_r), 48'(exp_req));
    chk({tag, restart ? " R10 single done" : " R9 single done"}, 48'(ndone_r), 48'h1);
  endtask

  task automatic run_elem(input string tag, input int vr, input int vc, input logic [1:0] m,
                          input logic sg, input logic [31:0] cap, input logic [31:0] base,
                          input int lat);
    logic [32:0] mp;
    int exp_req = 0;
    q_e.delete(); tag_e = tag; nreq_e = 0; ndone_e = 0;
    for (int r = 0; r < vr; r++) begin
      for (int c = 0; c < vc; c++) begin
        mp = ref_map(idx_mem_e[r*16+c], sg, m, cap);
        if (mp[32]) q_e.push_back({8'(r), 8'(c), 32'h0});
        else begin
          q_e.push_back({8'(r), 8'(c), tbl_val(base + mp[31:0])});
          exp_req++;
        end
      end
    end
    @(negedge clk);
    vr_e = 8'(vr); vc_e = 8'(vc); oob_e = m; sg_e = sg; cap_e = cap; base_e = base;
    lat_e = lat; start_e = 1'b1;
    @(negedge clk);
    start_e = 1'b0;
    chk({tag, " R9 busy after start"}, {47'h0, busy_e}, 48'h1);
    for (int k = 0; k < 5000; k++) begin
      if (done_e) break;
      @(negedge clk);
    end
    chk({tag, " R9 done seen"}, {47'h0, done_e}, 48'h1);
    @(negedge clk);
    chk({tag, " R9 idle after done"}, {47'h0, busy_e}, 48'h0);
    chk({tag, " R7 all writes made"}, 48'(q_e.size()), 48'h0);
    chk({tag, " R6 R8 table read count"}, 48'(nreq_e), 48'(exp_req));
    chk({tag, " R9 single done"}, 48'(ndone_e), 48'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) idx_mem_e[i] = 32'(i * 5 + 1);
    for (int i = 0; i < 16; i++) idx_mem_r[i] = 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy row", {47'h0, busy_r}, 48'h0);
    chk("R11 busy elem", {47'h0, busy_e}, 48'h0);
    chk("R11 outputs row", {44'h0, done_r, idx_rd_r, req_r, we_r}, 48'h0);
    chk("R11 outputs elem", {44'h0, done_e, idx_rd_e, req_e, we_e}, 48'h0);

    // R1 R3: padded pitch, no check
    idx_mem_r[0] = 3; idx_mem_r[1] = 0; idx_mem_r[2] = 15; idx_mem_r[3] = 7;
    run_row("R1 R3 row plain", 4, 5, 2'd0, 1'b0, 32'd16, 32'd100, 32'd8, 0, 1'b0);
    // R3: beyond capacity passes through
    idx_mem_r[0] = 40; idx_mem_r[1] = 2;
    run_row("R3 row unchecked", 2, 3, 2'd0, 1'b0, 32'd10, 32'd0, 32'd4, 1, 1'b0);
    // R4 R12: clamp with signed negative
    idx_mem_r[0] = 2; idx_mem_r[1] = 25; idx_mem_r[2] = 32'hFFFF_FFFE; idx_mem_r[3] = 9;
    run_row("R4 R12 row clamp", 4, 3, 2'd1, 1'b1, 32'd10, 32'd50, 32'd4, 2, 1'b0);
    // R5: wrap ignores the signed flag
    idx_mem_r[0] = 23; idx_mem_r[1] = 10; idx_mem_r[2] = 32'hFFFF_FFFF; idx_mem_r[3] = 4;
    run_row("R5 row wrap", 4, 2, 2'd2, 1'b1, 32'd10, 32'd7, 32'd3, 0, 1'b0);
    // R6 R12: zero fill, unsigned large index out of range
    idx_mem_r[0] = 1; idx_mem_r[1] = 10; idx_mem_r[2] = 32'h8000_0000; idx_mem_r[3] = 5;
    run_row("R6 R12 row zero", 4, 6, 2'd3, 1'b0, 32'd10, 32'd300, 32'd6, 1, 1'b0);
    // R10: second start while busy ignored
    idx_mem_r[0] = 3; idx_mem_r[1] = 0; idx_mem_r[2] = 15; idx_mem_r[3] = 7;
    run_row("R10 row restart", 4, 5, 2'd0, 1'b0, 32'd16, 32'd100, 32'd8, 1, 1'b1);

    // R7 R2: 1x1 element
    idx_mem_e[0] = 7;
    run_elem("R7 R2 elem 1x1", 1, 1, 2'd0, 1'b0, 32'd30, 32'd200, 0);
    // R2 R5: element wrap
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 4; c++)
        idx_mem_e[r*16+c] = 32'(r * 11 + c * 7) + ((c == 3) ? 32'hFFFF_FFF0 : 32'h0);
    run_elem("R2 R5 elem wrap", 3, 4, 2'd2, 1'b1, 32'd12, 32'd64, 2);
    // R6: element zero fill
    idx_mem_e[0] = 3; idx_mem_e[1] = 40; idx_mem_e[2] = 32'hFFFF_FFFF;
    idx_mem_e[16] = 39; idx_mem_e[17] = 0; idx_mem_e[18] = 100;
    run_elem("R6 R12 elem zero", 2, 3, 2'd3, 1'b1, 32'd40, 32'd500, 1);
    // R4: element clamp
    idx_mem_e[0] = 32'hFFFF_FFFB; idx_mem_e[1] = 50; idx_mem_e[16] = 0; idx_mem_e[17] = 49;
    run_elem("R4 elem clamp", 2, 2, 2'd1, 1'b1, 32'd50, 32'd1000, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule